// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block is the control front end of a boot-block flash array. A microprocessor writes 8-bit command bytes on the low data lines. The controller keeps the current read mode (array, status or identifier). It launches program and erase operations on a stand-in write engine that stays busy for a fixed number of cycles, and it keeps a status register with a ready bit and sticky error flags.

Every alteration passes through a per-sector permission check. The inputs to that check are:
- the level of the reset pin: low, high or high-voltage;
- a flag saying the programming supply is above its lockout threshold;
- the write-protect pin;
- a configuration input that tells the controller to disregard write-protect.

An address decoder splits the 256 KB space into one 16 KB boot sector, two 8 KB parameter sectors, a 96 KB main sector and a 128 KB main sector. A build parameter places the boot sector at the bottom or the top of the space. Write-protect guards only the boot sector.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After system reset, or when the reset pin leaves the low level, the mode is array (mode code 0) and the status byte reads 0x80.
- R2: When not busy, a written byte 0xFF selects array mode (code 0), 0x70 selects status mode (code 1) and 0x90 selects identifier mode (code 2). Any byte that is not a command leaves the mode and status unchanged.
- R3: Address bits [17:13] form an 8 KB unit index. With the boot sector at the bottom, units 0-1 are boot, 2 and 3 are parameter, 4-15 are the 96 KB main sector and 16-31 are the 128 KB main sector. With the boot sector at the top, the order is mirrored, so units 30-31 are boot.
- R4: Status bit 7 is the ready flag. While the engine is busy, bit 7 is 0 and every write is ignored. The engine runs for BUSY_CYC cycles after the accepting write. After that, bit 7 returns to 1 and commands are accepted again.
- R5: While the reset pin is low, pd_o is 1, writes have no effect, the engine is stopped and the controller state is held at its reset value.
- R6: With the supply below lockout, every sector is locked. A program attempt sets status bits 4 and 3, and an erase attempt sets bits 5 and 3. The engine does not start.
- R7: With the reset pin high, the supply above lockout and write-protect low, only the boot sector is locked. A program there sets status bit 4 without starting the engine. Parameter and main sectors start the engine.
- R8: With write-protect high, every sector is unlocked, unless the ignore-write-protect input is set. In that case the boot sector is unlocked only when the reset pin is at the high-voltage level. The high-voltage level unlocks every sector regardless of write-protect.
- R9: 0x40 followed by any byte programs the sector of the second write's address. 0x20 followed by 0xD0 erases the addressed sector. An accepted or refused program or erase switches the mode to status. 0x20 followed by any other byte sets status bits 5 and 4 and returns to array mode.
- R10: Error bits 5, 4 and 3 stay set until a 0x50 write clears them. Bits 6, 2, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| rp_lvl | input | 2 | Reset pin level: 0 low, 1 high, 2 high-voltage (3 treated as high) |
| vpp_ok | input | 1 | Programming supply above lockout |
| wp | input | 1 | Write-protect pin, low protects boot sector |
| wp_ignore | input | 1 | Disregard write-protect; boot unlock needs high-voltage reset level |
| wr_en | input | 1 | One-cycle bus write strobe |
| addr | input | ADDR_W | Byte address of the write |
| wdata | input | 8 | Low data byte of the write |
| mode_o | output | 2 | Read mode: 0 array, 1 status, 2 identifier |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Write engine busy |
| pd_o | output | 1 | Powered down (reset pin low) |

## Verification
The bench programs every 8 KB unit under both boot placements and with write-protect low. A decoder with a misplaced boundary or a mirror error shows up as a wrong error bit or a missing busy flag on exactly one unit. It writes mode commands during a busy period, where a controller that did not gate writes would leave status mode. It issues an erase setup followed by a wrong byte, where a missing sequence check would start an erase. It walks the reset-pin level, write-protect and ignore-write-protect combinations on the boot sector, so that any inverted term in the lock equation turns a refusal into a start or the other way round.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [1:0] {
        RP_LOW  = 2'd0,
        RP_HIGH = 2'd1,
        RP_HV   = 2'd2
    } rp_e;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_STATUS = 2'd1,
        MD_ID     = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PROG  = 2'd1,
        PH_ERASE = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        SEC_BOOT  = 3'd0,
        SEC_PARA  = 3'd1,
        SEC_PARB  = 3'd2,
        SEC_MAINS = 3'd3,
        SEC_MAINL = 3'd4
    } sector_e;

    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_STATUS = 8'h70;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_CLEAR  = 8'h50;
    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_CONF   = 8'hD0;

    typedef struct packed {
        phase_e phase;
        mode_e  mode;
        logic   err_erase;
        logic   err_prog;
        logic   err_vpp;
    } ctl_t;

    localparam ctl_t CTL_RST = '{phase: PH_IDLE, mode: MD_ARRAY,
                                 err_erase: 1'b0, err_prog: 1'b0, err_vpp: 1'b0};

endpackage

// File: rtl/flash_sector_dec.sv
module flash_sector_dec #(
    parameter int ADDR_W   = 18,
    parameter int UNIT_AW  = 13,
    parameter int BOOT_U   = 2,
    parameter int PAR_U    = 1,
    parameter int MAINS_U  = 12,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic [ADDR_W-1:0]  addr,
    output flash_pkg::sector_e sector,
    output logic               is_boot
);
    import flash_pkg::*;

    localparam int IDX_W = ADDR_W - UNIT_AW;
    localparam int UNITS = 1 << IDX_W;
    localparam int LIM_B = BOOT_U;
    localparam int LIM_A = LIM_B + PAR_U;
    localparam int LIM_P = LIM_A + PAR_U;
    localparam int LIM_S = LIM_P + MAINS_U;

    logic [IDX_W-1:0] unit_idx;
    logic [IDX_W-1:0] rel_idx;

    assign unit_idx = addr[ADDR_W-1:UNIT_AW];

    generate
        if (BOOT_TOP) begin : g_top
            assign rel_idx = IDX_W'(UNITS - 1) - unit_idx;
        end else begin : g_bottom
            assign rel_idx = unit_idx;
        end
    endgenerate

    always_comb begin
        if (int'(rel_idx) < LIM_B)      sector = SEC_BOOT;
        else if (int'(rel_idx) < LIM_A) sector = SEC_PARA;
        else if (int'(rel_idx) < LIM_P) sector = SEC_PARB;
        else if (int'(rel_idx) < LIM_S) sector = SEC_MAINS;
        else                            sector = SEC_MAINL;
    end

    assign is_boot = (sector == SEC_BOOT);

endmodule

// File: rtl/flash_lock_eval.sv
module flash_lock_eval (
    input  logic [1:0] rp_lvl,
    input  logic       vpp_ok,
    input  logic       wp,
    input  logic       wp_ignore,
    input  logic       is_boot,
    output logic       locked,
    output logic       lockout
);
    import flash_pkg::*;

    logic rp_low;
    logic rp_hv;
    logic boot_guard;

    assign rp_low     = (rp_lvl == RP_LOW);
    assign rp_hv      = (rp_lvl == RP_HV);
    assign lockout    = !vpp_ok;
    assign boot_guard = is_boot && !rp_hv && (wp_ignore || !wp);
    assign locked     = rp_low || lockout || boot_guard;

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (halt)               cnt_d = '0;
        else if (start)         cnt_d = CNT_W'(BUSY_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R4
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R4
    busy_runs_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !halt) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int ADDR_W   = 18,
    parameter int UNIT_AW  = 13,
    parameter int BOOT_U   = 2,
    parameter int PAR_U    = 1,
    parameter int MAINS_U  = 12,
    parameter bit BOOT_TOP = 1'b0,
    parameter int BUSY_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rp_lvl,
    input  logic              vpp_ok,
    input  logic              wp,
    input  logic              wp_ignore,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [1:0]        mode_o,
    output logic [7:0]        status_o,
    output logic              busy_o,
    output logic              pd_o
);
    import flash_pkg::*;

    ctl_t    ctl_d, ctl_q;
    sector_e sector;
    logic    is_boot;
    logic    locked;
    logic    lockout;
    logic    pd;
    logic    busy;
    logic    start;

    assign pd = (rp_lvl == RP_LOW);

    flash_sector_dec #(
        .ADDR_W  (ADDR_W),
        .UNIT_AW (UNIT_AW),
        .BOOT_U  (BOOT_U),
        .PAR_U   (PAR_U),
        .MAINS_U (MAINS_U),
        .BOOT_TOP(BOOT_TOP)
    ) i_dec (
        .addr   (addr),
        .sector (sector),
        .is_boot(is_boot)
    );

    flash_lock_eval i_lock (
        .rp_lvl   (rp_lvl),
        .vpp_ok   (vpp_ok),
        .wp       (wp),
        .wp_ignore(wp_ignore),
        .is_boot  (is_boot),
        .locked   (locked),
        .lockout  (lockout)
    );

    flash_busy_timer #(.BUSY_CYC(BUSY_CYC)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .halt (pd),
        .start(start),
        .busy (busy)
    );

    always_comb begin
        ctl_d = ctl_q;
        start = 1'b0;
        if (pd) begin
            ctl_d = CTL_RST;
        end else if (wr_en && !busy) begin
            unique case (ctl_q.phase)
                PH_PROG: begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.mode  = MD_STATUS;
                    if (locked) begin
                        ctl_d.err_prog = 1'b1;
                        if (lockout) ctl_d.err_vpp = 1'b1;
                    end else begin
                        start = 1'b1;
                    end
                end
                PH_ERASE: begin
                    ctl_d.phase = PH_IDLE;
                    if (wdata != CMD_CONF) begin
                        ctl_d.err_erase = 1'b1;
                        ctl_d.err_prog  = 1'b1;
                        ctl_d.mode      = MD_ARRAY;
                    end else begin
                        ctl_d.mode = MD_STATUS;
                        if (locked) begin
                            ctl_d.err_erase = 1'b1;
                            if (lockout) ctl_d.err_vpp = 1'b1;
                        end else begin
                            start = 1'b1;
                        end
                    end
                end
                default: begin
                    case (wdata)
                        CMD_ARRAY:  ctl_d.mode  = MD_ARRAY;
                        CMD_STATUS: ctl_d.mode  = MD_STATUS;
                        CMD_IDENT:  ctl_d.mode  = MD_ID;
                        CMD_PROG:   ctl_d.phase = PH_PROG;
                        CMD_ERASE:  ctl_d.phase = PH_ERASE;
                        CMD_CLEAR: begin
                            ctl_d.err_erase = 1'b0;
                            ctl_d.err_prog  = 1'b0;
                            ctl_d.err_vpp   = 1'b0;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign mode_o   = ctl_q.mode;
    assign busy_o   = busy;
    assign pd_o     = pd;
    assign status_o = {!busy, 1'b0, ctl_q.err_erase, ctl_q.err_prog, ctl_q.err_vpp, 3'b000};

    // R4
    busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pd) |=> $stable(mode_o));

    // R5
    pd_state_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> (mode_o == MD_ARRAY && !busy_o && status_o[5:3] == 3'b000));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[4] && !pd && !(wr_en && !busy && ctl_q.phase == PH_IDLE && wdata == CMD_CLEAR))
        |=> status_o[4]);

    // R6
    lockout_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_ok && !busy_o) |=> !busy_o);

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rp_lvl = 2'd1;
    logic        vpp_ok = 1'b1;
    logic        wp = 1'b0;
    logic        wp_ignore = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [1:0]  mode_b, mode_t;
    logic [7:0]  stat_b, stat_t;
    logic        busy_b, busy_t, pd_b, pd_t;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl i_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .rp_lvl(rp_lvl), .vpp_ok(vpp_ok), .wp(wp),
        .wp_ignore(wp_ignore), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mode_o(mode_b), .status_o(stat_b), .busy_o(busy_b), .pd_o(pd_b)
    );

    flash_cmd_ctrl #(.BOOT_TOP(1'b1)) i_flash_cmd_ctrl_top (
        .clk(clk), .rst_n(rst_n), .rp_lvl(rp_lvl), .vpp_ok(vpp_ok), .wp(wp),
        .wp_ignore(wp_ignore), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mode_o(mode_t), .status_o(stat_t), .busy_o(busy_t), .pd_o(pd_t)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        idle(BUSY + 1);
        wr(18'h0, 8'h50);
        wr(18'h0, 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk({6'b0, mode_b}, 8'd0, "R1 mode");
        chk(stat_b, 8'h80, "R1 status");
        chk({7'b0, busy_b}, 8'd0, "R1 busy");

        // R2 mode commands
        wr(18'h0, 8'h70); chk({6'b0, mode_b}, 8'd1, "R2 status mode");
        wr(18'h0, 8'h90); chk({6'b0, mode_b}, 8'd2, "R2 ident mode");
        wr(18'h0, 8'h11); chk({6'b0, mode_b}, 8'd2, "R2 unknown byte");
        chk(stat_b, 8'h80, "R2 unknown byte status");
        wr(18'h0, 8'hFF); chk({6'b0, mode_b}, 8'd0, "R2 array mode");

        // R3 R7 sweep every unit, both placements, wp low
        for (int u = 0; u < 32; u++) begin
            logic lb, lt;
            lb = (u < 2);
            lt = (u >= 30);
            wr(18'(u) << 13, 8'h40);
            wr(18'(u) << 13, 8'hA5);
            chk(stat_b, lb ? 8'h90 : 8'h00, "R3 R7 bottom map");
            chk(stat_t, lt ? 8'h90 : 8'h00, "R3 R7 top map");
            chk({6'b0, mode_b}, 8'd1, "R9 program to status");
            settle();
        end

        // R8 wp high unlocks boot
        wp = 1'b1;
        wr(18'h0, 8'h40); wr(18'h0, 8'h00);
        chk({7'b0, busy_b}, 8'd1, "R8 wp high boot start");
        settle();
        // R8 ignore wp: boot locked at high level
        wp_ignore = 1'b1;
        wr(18'h0, 8'h40); wr(18'h0, 8'h00);
        chk(stat_b, 8'h90, "R8 ignore wp boot locked");
        settle();
        // R8 high-voltage level unlocks
        rp_lvl = 2'd2;
        wr(18'h0, 8'h40); wr(18'h0, 8'h00);
        chk({7'b0, busy_b}, 8'd1, "R8 hv unlock");
        settle();
        wp = 1'b0; wp_ignore = 1'b0;
        wr(18'h0, 8'h20); wr(18'h0, 8'hD0);
        chk({7'b0, busy_b}, 8'd1, "R8 hv unlock wp low");
        settle();
        rp_lvl = 2'd1;

        // R6 supply lockout
        vpp_ok = 1'b0;
        wr(18'h30000, 8'h40); wr(18'h30000, 8'h00);
        chk(stat_b, 8'h98, "R6 program lockout");
        settle();
        wr(18'h30000, 8'h20); wr(18'h30000, 8'hD0);
        chk(stat_b, 8'hA8, "R6 erase lockout");
        settle();
        vpp_ok = 1'b1;

        // R9 erase sequence error
        wr(18'h30000, 8'h20); wr(18'h30000, 8'h33);
        chk(stat_b, 8'hB0, "R9 seq error status");
        chk({6'b0, mode_b}, 8'd0, "R9 seq error mode");
        chk({7'b0, busy_b}, 8'd0, "R9 seq error no start");
        // R10 sticky, then cleared
        wr(18'h0, 8'h70);
        chk(stat_b, 8'hB0, "R10 sticky");
        wr(18'h0, 8'h50);
        chk(stat_b, 8'h80, "R10 clear");
        wr(18'h0, 8'hFF);

        // R9 R4 erase accepted, writes ignored while busy
        wr(18'h30000, 8'h20); wr(18'h30000, 8'hD0);
        chk(stat_b, 8'h00, "R4 busy status");
        chk({6'b0, mode_b}, 8'd1, "R9 erase to status");
        wr(18'h0, 8'hFF);
        chk({6'b0, mode_b}, 8'd1, "R4 write ignored while busy");
        wr(18'h0, 8'h90);
        chk({6'b0, mode_b}, 8'd1, "R4 ident ignored while busy");
        // accept edge at write 2; 2 ignored writes used 4 cycles of BUSY
        idle(BUSY - 5);
        chk({7'b0, busy_b}, 8'd1, "R4 busy last cycle");
        idle(1);
        chk(stat_b, 8'h80, "R4 ready after busy time");
        wr(18'h0, 8'h90);
        chk({6'b0, mode_b}, 8'd2, "R4 full set again");

        // R5 reset pin low
        rp_lvl = 2'd0;
        idle(1);
        chk({7'b0, pd_b}, 8'd1, "R5 pd flag");
        chk({6'b0, mode_b}, 8'd0, "R5 mode reset");
        wr(18'h0, 8'h70);
        chk({6'b0, mode_b}, 8'd0, "R5 write ignored");
        rp_lvl = 2'd1;
        idle(1);
        chk({7'b0, pd_b}, 8'd0, "R1 pd released");
        chk(stat_b, 8'h80, "R1 status after release");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule